// File: doc/BRIEF.md
# Flash Bus Front-End with Write Inhibit

This block sits between the host pins of a parallel NOR-style flash model and its internal command logic. It runs on an internal sampling clock. Every host pin passes through a two-stage synchronizer. The active-low chip-enable, output-enable and write-enable pins each go through a glitch filter. The decoded result is either a read, or a qualified write cycle that ends in a one-cycle strobe toward the command register.

A width pin selects 16-bit word mode or 8-bit byte mode. In byte mode the top data pin serves as an extra low address bit, and the read path returns only the selected byte on the low lane. Command writes are always one byte wide. A low-supply flag resets the command side to read mode and blocks writes. After power-up, or after the flag clears, write-enable must be seen high once before a new write can be accepted.

Top module: `flash_bus_frontend`

## Requirements
- R1: With `byte_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, `dq_out` equals `rd_word` and both `dq_oe_lo` and `dq_oe_hi` are 1.
- R2: With `byte_n`=0 and the same read condition, `dq_oe_lo`=1 and `dq_oe_hi`=0. `dq_out[15:8]`=0. `dq_out[7:0]` is `rd_word[15:8]` when `dq_in[15]`=1 and `rd_word[7:0]` when it is 0.
- R3: When the read condition does not hold (`ce_n`=1, `oe_n`=1 or `we_n`=0), both lane enables are 0 and `dq_out` is 0.
- R4: A write cycle starts when `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together. It ends when `ce_n` or `we_n` returns high, and the end raises `cmd_wr` for exactly one cycle. `cmd_data` is `dq_in[7:0]` as it was at the start of the cycle. `dq_in[14:8]` has no effect.
- R5: `cmd_addr` is `{addr, lsb}`, where `lsb` is `dq_in[15]` in byte mode and 0 in word mode, taken at the start of the cycle.
- R6: Holding `oe_n`=0 while `ce_n` and `we_n` are low produces no `cmd_wr`.
- R7: A rising `low_vcc` gives one `rst_read` pulse of one cycle. While `low_vcc` is 1, no write is accepted. A write in progress when it rises ends without a strobe.
- R8: After reset, and after `low_vcc` clears, no write is accepted until `we_n` has been sampled high. A `we_n` rise that ends a low held since reset or since the flag cleared gives no strobe.
- R9: A low pulse on `we_n` or `ce_n` lasting fewer than `GLITCH_CYC` sampling cycles does not start a write cycle.
- R10: During and directly after reset, `cmd_wr`, `rst_read`, `dq_oe_lo` and `dq_oe_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = word mode, 0 = byte mode |
| low_vcc | input | 1 | Supply below lockout level |
| addr | input | ADDR_W | Word address pins |
| dq_in | input | 16 | Data pins as driven by the host; bit 15 is the low address bit in byte mode |
| rd_word | input | 16 | Array word at `rd_addr` |
| rd_addr | output | ADDR_W | Synchronized address toward the array |
| dq_out | output | 16 | Read data toward the pins |
| dq_oe_lo | output | 1 | Drive enable for data bits 7..0 |
| dq_oe_hi | output | 1 | Drive enable for data bits 15..8 |
| cmd_wr | output | 1 | One-cycle command write strobe |
| cmd_addr | output | ADDR_W+1 | Byte address of the command write |
| cmd_data | output | 8 | Command byte |
| rst_read | output | 1 | Reset-to-read pulse |

## Verification
The hardest state to reach from the ports is the unarmed state in which the write condition is already true. This happens at power-up, and again when the supply flag drops while `ce_n` and `we_n` are both held low. The stimulus gets there by holding those pins low through reset, or through a whole low-supply episode. It then raises `we_n` and expects no strobe, and only after a fresh high-low-high sequence does it expect one. Aborting a write in progress is reached by raising `low_vcc` between the two edges of a long write pulse.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    localparam int DQ_W  = 16;
    localparam int CMD_W = 8;
    localparam int NCTL  = 3;
    localparam int CTL_CE = 0;
    localparam int CTL_OE = 1;
    localparam int CTL_WE = 2;

    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_ACTIVE = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic read_ok;
        logic write_ok;
    } bus_dec_t;

    typedef struct packed {
        logic [DQ_W-1:0] data;
        logic            oe_lo;
        logic            oe_hi;
    } rd_bus_t;

    function automatic bus_dec_t decode_ctl(logic [NCTL-1:0] low);
        bus_dec_t d;
        d.read_ok  = low[CTL_CE] & low[CTL_OE] & ~low[CTL_WE];
        d.write_ok = low[CTL_CE] & low[CTL_WE] & ~low[CTL_OE];
        return d;
    endfunction

    function automatic logic [DQ_W-1:0] pick_lane(logic byte_mode, logic lsb,
                                                  logic [DQ_W-1:0] w);
        if (!byte_mode)
            return w;
        return {{(DQ_W-CMD_W){1'b0}}, (lsb ? w[DQ_W-1:CMD_W] : w[CMD_W-1:0])};
    endfunction
endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         settled
);
    logic [W-1:0] meta;
    logic [1:0]   vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
            vld  <= '0;
        end else begin
            meta <= d;
            q    <= meta;
            vld  <= {vld[0], 1'b1};
        end
    end

    assign settled = vld[1];
endmodule

// File: rtl/fbf_glitch.sv
module fbf_glitch #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic low_q
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            low_q <= 1'b0;
        end else if (pin_n) begin
            cnt   <= '0;
            low_q <= 1'b0;
        end else if (cnt == LIM) begin
            low_q <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fbf_wrqual.sv
module fbf_wrqual
    import fbf_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              write_ok,
    input  logic              we_hi_s,
    input  logic              settled,
    input  logic              lv_s,
    input  logic              byte_mode,
    input  logic              lsb_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [CMD_W-1:0]  data_s,
    output logic              cmd_wr,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              rst_read,
    output logic              armed
);
    wr_state_e state;
    logic      lv_d;

    always_ff @(posedge clk) begin
        if (rst || lv_s)
            armed <= 1'b0;
        else if (settled && we_hi_s)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lv_d     <= 1'b0;
            rst_read <= 1'b0;
        end else begin
            lv_d     <= lv_s;
            rst_read <= lv_s & ~lv_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WR_IDLE;
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            cmd_wr <= 1'b0;
            unique case (state)
                WR_IDLE: begin
                    if (write_ok && armed && !lv_s) begin
                        state    <= WR_ACTIVE;
                        cmd_addr <= {addr_s, (byte_mode ? lsb_s : 1'b0)};
                        cmd_data <= data_s;
                    end
                end
                WR_ACTIVE: begin
                    if (lv_s) begin
                        state <= WR_IDLE;
                    end else if (!write_ok) begin
                        state  <= WR_IDLE;
                        cmd_wr <= 1'b1;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fbf_rdsteer.sv
module fbf_rdsteer
    import fbf_pkg::*;
(
    input  logic            read_ok,
    input  logic            byte_mode,
    input  logic            lsb_s,
    input  logic [DQ_W-1:0] rd_word,
    output rd_bus_t         rd
);
    always_comb begin
        rd = '0;
        if (read_ok) begin
            rd.data  = pick_lane(byte_mode, lsb_s, rd_word);
            rd.oe_lo = 1'b1;
            rd.oe_hi = ~byte_mode;
        end
    end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
    import fbf_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int GLITCH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_n,
    input  logic              low_vcc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic [15:0]       rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              cmd_wr,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              rst_read
);
    localparam int SW = ADDR_W + CMD_W + 1 + NCTL + 2;
    localparam logic [SW-1:0] SRST = {1'b0, 1'b1, {NCTL{1'b1}}, 1'b0, {CMD_W{1'b0}}, {ADDR_W{1'b0}}};

    logic [SW-1:0]     raw, syn;
    logic              settled;
    logic              lv_s, byte_n_s, lsb_s;
    logic [NCTL-1:0]   ctl_s, ctl_low;
    logic [CMD_W-1:0]  data_s;
    logic [ADDR_W-1:0] addr_s;
    logic              armed;
    logic              unused_hi;
    bus_dec_t          dec;
    rd_bus_t           rd;

    assign unused_hi = ^dq_in[DQ_W-2:CMD_W];

    assign raw = {low_vcc, byte_n, we_n, oe_n, ce_n, dq_in[DQ_W-1], dq_in[CMD_W-1:0], addr};

    fbf_sync #(.W(SW), .RST_VAL(SRST)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn), .settled(settled)
    );

    assign {lv_s, byte_n_s, ctl_s, lsb_s, data_s, addr_s} = syn;

    for (genvar g = 0; g < NCTL; g++) begin : g_filt
        fbf_glitch #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk(clk), .rst(rst), .pin_n(ctl_s[g]), .low_q(ctl_low[g])
        );
    end

    assign dec = decode_ctl(ctl_low);

    fbf_wrqual #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .write_ok(dec.write_ok), .we_hi_s(ctl_s[CTL_WE]),
        .settled(settled), .lv_s(lv_s), .byte_mode(~byte_n_s), .lsb_s(lsb_s),
        .addr_s(addr_s), .data_s(data_s), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rst_read(rst_read), .armed(armed)
    );

    fbf_rdsteer u_rd (
        .read_ok(dec.read_ok), .byte_mode(~byte_n_s), .lsb_s(lsb_s),
        .rd_word(rd_word), .rd(rd)
    );

    assign rd_addr  = addr_s;
    assign dq_out   = rd.data;
    assign dq_oe_lo = rd.oe_lo;
    assign dq_oe_hi = rd.oe_hi;
endmodule

// File: rtl/fbf_chk.sv
module fbf_chk (
    input logic clk,
    input logic rst,
    input logic lv_s,
    input logic byte_n_s,
    input logic armed,
    input logic dq_oe_lo,
    input logic dq_oe_hi,
    input logic cmd_wr,
    input logic rst_read
);
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !cmd_wr);

    p_lowvcc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (lv_s && $past(lv_s)) |-> !cmd_wr);

    p_rstread_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(lv_s) |=> rst_read);

    p_rstread_single_r7: assert property (@(posedge clk) disable iff (rst)
        rst_read |=> !rst_read);

    p_byte_hi_off_r2: assert property (@(posedge clk) disable iff (rst)
        !byte_n_s |-> !dq_oe_hi);

    p_lane_pair_r1: assert property (@(posedge clk) disable iff (rst)
        dq_oe_hi |-> dq_oe_lo);

    p_armed_write_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> armed);
endmodule

bind flash_bus_frontend fbf_chk u_chk (
    .clk(clk), .rst(rst), .lv_s(lv_s), .byte_n_s(byte_n_s), .armed(armed),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .cmd_wr(cmd_wr), .rst_read(rst_read)
);

// File: tb/flash_bus_frontend_tb_top.sv
module flash_bus_frontend_tb_top;
    localparam int ADDR_W = 19;
    localparam int NV = 7;
    localparam int SETTLE = 12;

    // ce oe we byte_n lsb rd_word exp_lo exp_hi exp_dq
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA55A, 1'b1, 1'b1, 16'hA55A},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA55A, 1'b1, 1'b0, 16'h005A},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA55A, 1'b1, 1'b0, 16'h00A5},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1'b1, 1'b1, 16'hBEEF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1, low_vcc = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0, rd_word = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0] dq_out;
    logic dq_oe_lo, dq_oe_hi, cmd_wr, rst_read;
    logic [ADDR_W:0] cmd_addr;
    logic [7:0] cmd_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, rr_cnt = 0;
    logic [ADDR_W:0] last_addr = '0;
    logic [7:0] last_data = '0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_bus_frontend #(.ADDR_W(ADDR_W), .GLITCH_CYC(4)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
        .low_vcc(low_vcc), .addr(addr), .dq_in(dq_in), .rd_word(rd_word),
        .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rst_read(rst_read)
    );

    always @(posedge clk) begin
        if (!rst && cmd_wr) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= cmd_addr;
            last_data <= cmd_data;
        end
        if (!rst && rst_read) rr_cnt <= rr_cnt + 1;
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        // R10: reset state
        wait_cyc(6);
        check("R10 cmd_wr in reset", cmd_wr, 0);
        check("R10 lanes in reset", {dq_oe_hi, dq_oe_lo}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 rst_read after reset", rst_read, 0);
        check("R10 lanes after reset", {dq_oe_hi, dq_oe_lo}, 0);
        wait_cyc(SETTLE);

        // R1 R2 R3: read vector table
        for (int i = 0; i < NV; i++) begin
            {ce_n, oe_n, we_n, byte_n, dq_in[15], rd_word} = VEC[i][38:18];
            wait_cyc(SETTLE);
            check("R1/R2/R3 dq_out", dq_out, VEC[i][15:0]);
            check("R1/R2/R3 lanes", {dq_oe_lo, dq_oe_hi}, VEC[i][17:16]);
        end
        ce_n = 1; oe_n = 1; we_n = 1; byte_n = 1; wait_cyc(SETTLE);
        check("R6 no write from reads with oe low", wr_cnt, 0);

        // R4 R5: word-mode write ended by we_n; upper data bits ignored
        addr = 19'h1234; dq_in = 16'h7FAA;
        ce_n = 0; wait_cyc(4); we_n = 0; wait_cyc(SETTLE);
        dq_in = 16'h0000;
        we_n = 1; wait_cyc(SETTLE); ce_n = 1; wait_cyc(SETTLE);
        check("R4 one strobe word mode", wr_cnt, 1);
        check("R4 cmd_data low byte", last_data, 8'hAA);
        check("R5 cmd_addr word mode", last_addr, {19'h1234, 1'b0});

        // R4 R5: byte-mode write ended by ce_n
        byte_n = 0; addr = 19'h00F0; dq_in = 16'h8055;
        we_n = 0; wait_cyc(4); ce_n = 0; wait_cyc(SETTLE);
        ce_n = 1; wait_cyc(SETTLE); we_n = 1; wait_cyc(SETTLE);
        check("R4 one strobe ce ends", wr_cnt, 2);
        check("R4 cmd_data byte mode", last_data, 8'h55);
        check("R5 cmd_addr byte mode lsb", last_addr, {19'h00F0, 1'b1});
        byte_n = 1;

        // R9: short we_n pulse while ce_n low
        ce_n = 0; wait_cyc(SETTLE);
        we_n = 0; wait_cyc(2); we_n = 1; wait_cyc(SETTLE);
        ce_n = 1; wait_cyc(SETTLE);
        check("R9 short we pulse ignored", wr_cnt, 2);

        // R9: short ce_n pulse while we_n low
        we_n = 0; wait_cyc(SETTLE);
        ce_n = 0; wait_cyc(2); ce_n = 1; wait_cyc(SETTLE);
        we_n = 1; wait_cyc(SETTLE);
        check("R9 short ce pulse ignored", wr_cnt, 2);

        // R6: oe_n low blocks write
        oe_n = 0; ce_n = 0; wait_cyc(4); we_n = 0; wait_cyc(SETTLE);
        we_n = 1; wait_cyc(SETTLE); ce_n = 1; oe_n = 1; wait_cyc(SETTLE);
        check("R6 oe low blocks write", wr_cnt, 2);

        // R7: low supply pulse and ignored write
        low_vcc = 1; wait_cyc(SETTLE);
        check("R7 one rst_read pulse", rr_cnt, 1);
        ce_n = 0; we_n = 0; wait_cyc(SETTLE);
        low_vcc = 0; wait_cyc(SETTLE);
        // R8: we_n held low across recovery, its rise gives no strobe
        we_n = 1; wait_cyc(SETTLE);
        check("R7/R8 no write during or after low supply", wr_cnt, 2);
        we_n = 0; wait_cyc(SETTLE); we_n = 1; wait_cyc(SETTLE);
        check("R8 write accepted once rearmed", wr_cnt, 3);
        ce_n = 1; wait_cyc(SETTLE);

        // R7: abort a write in progress
        ce_n = 0; we_n = 0; wait_cyc(SETTLE);
        low_vcc = 1; wait_cyc(SETTLE);
        we_n = 1; wait_cyc(SETTLE);
        low_vcc = 0; ce_n = 1; wait_cyc(SETTLE);
        check("R7 aborted write no strobe", wr_cnt, 3);
        check("R7 second rst_read pulse", rr_cnt, 2);

        // R8: power-up with write condition already true
        base = wr_cnt;
        rst = 1; ce_n = 0; we_n = 0; oe_n = 1; wait_cyc(6);
        rst = 0; wait_cyc(SETTLE);
        we_n = 1; wait_cyc(SETTLE);
        ce_n = 1; wait_cyc(SETTLE);
        check("R8 power-up we rise ignored", wr_cnt, base);

        finish_run();
    end
endmodule